// File: doc/BRIEF.md
# Two-Wire Serial Debug Port Target

This block is the target end of a two-wire serial debug link. It runs on the serial clock and samples the bidirectional data line at each rising edge. A line-reset detector starts every session. After that, 8-bit request packets are decoded and answered with a 3-bit acknowledge. Each accepted request then moves one 32-bit word with even parity, and the block inserts the turnaround cycles in which the line changes hands. The debug-port side holds four registers: a fixed identification word, control/status with the power-up request/acknowledge pairs, an access-port select register, and a read buffer.

Access-port accesses are routed by the selected port number. Port 0 is a small built-in test port, with an identification word and a scratch register. Every other port number is forwarded to a single-cycle register bus. Access-port reads are posted. The word shifted out during such a read is the previous read-buffer contents, and the freshly read value is captured into the read buffer. That value can then be collected by the next access-port read or by a read of the read buffer.

Top module: `swd_target`

## Requirements
- R1: After reset the target ignores the line and never drives it until it has seen a line reset: at least 50 consecutive samples high followed by two samples low. A run of 50 highs at any later time aborts the transfer in progress.
- R2: After each line reset, only a debug-port read of address 0 is answered. That read returns 0x0BB11477. Any other request gets no acknowledge until it has been done.
- R3: A request is start(1), port-select (1 = access port), read (1 = read), A2, A3, even parity over those four, stop(0), park(1). A parity or framing error gets no acknowledge and the line stays undriven.
- R4: One turnaround cycle follows park. Then the acknowledge is driven LSB first on three cycles: OK = 3'b001, FAULT = 3'b100. A write adds one more turnaround before the host's data.
- R5: Read data is driven immediately after the acknowledge: 32 bits LSB first, then one even-parity bit. The line is released after the parity bit.
- R6: Control/status is debug-port address 1 (byte offset 4). Bit 30 is the system power-up request and bit 28 the debug power-up request; both are writable and appear on outputs. Bits 31 and 29 are their acknowledges and follow the requests one cycle later. Bit 7 is the sticky write-data error.
- R7: Select is debug-port address 2 (offset 8). Bits 31:24 choose the access port and bits 7:4 the bank. The access-port byte address is {bank, A3, A2, 2'b00}. Select reads back as written.
- R8: An access-port read shifts out the old read-buffer value and loads the new result into the read buffer. The read buffer is debug-port address 3 (offset 0xC).
- R9: Port 0 returns 0x04770021 at byte address 0xFC. It has a read/write scratch register at 0x00 and reads 0 elsewhere.
- R10: For a non-zero port, an access raises the bus strobe for one cycle with port, address, write flag and write data. A read captures the bus read data in that cycle.
- R11: A write whose data parity is wrong leaves its target register unchanged and sets the sticky error bit.
- R12: While the sticky error is set, access-port accesses and read-buffer reads get FAULT and have no data phase or side effect. A debug-port write to address 0 with bit 3 set clears the error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial debug clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| swdio_i | input | 1 | Data line as seen at the pin |
| swdio_o | output | 1 | Data value driven by the target |
| swdio_oe_o | output | 1 | Target drives the data line |
| sys_pwrup_req_o | output | 1 | System power-up request |
| dbg_pwrup_req_o | output | 1 | Debug power-up request |
| ap_req_o | output | 1 | Register-bus access strobe |
| ap_wr_o | output | 1 | Register-bus write flag |
| ap_sel_o | output | 8 | Selected access-port number |
| ap_addr_o | output | 8 | Access-port byte address |
| ap_wdata_o | output | 32 | Register-bus write data |
| ap_rdata_i | input | 32 | Register-bus read data |

## Verification
The bench first plays the ordinary bring-up session and checks every word returned: identification, power-up, bank select, a posted access-port read, and then the read buffer. A design that returns the access-port value in the same transfer, instead of posting it, fails at the stale word. The bench sends requests before any line reset, a non-identification request straight after a line reset, and requests with bad parity or a bad stop bit. A target that answers any of these shows an acknowledge where none may appear. A write with corrupted data parity must leave select unchanged and raise the sticky bit, and the following access-port accesses must then be refused with FAULT. A design that commits bad writes, or serves accesses while the error is set, shows a changed select value or an OK acknowledge.

// File: rtl/swd_pkg.sv
package swd_pkg;
  typedef enum logic [2:0] {
    ST_RST, ST_IDLE, ST_REQ, ST_TRN1, ST_ACK, ST_RDATA, ST_TRN2, ST_WDATA
  } swd_state_e;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;
endpackage

// File: rtl/swd_line_reset.sv
module swd_line_reset #(
  parameter int LR_HIGH = 50,
  parameter int LR_LOW  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic armed_o,
  output logic done_o
);
  localparam int HW = $clog2(LR_HIGH + 1);
  localparam int LW = $clog2(LR_LOW + 1);

  logic [HW-1:0] hi_q;
  logic [LW-1:0] lo_q;

  assign armed_o = (hi_q == HW'(LR_HIGH));
  assign done_o  = armed_o && !line_i && (lo_q == LW'(LR_LOW - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (line_i) begin
      lo_q <= '0;
      if (!armed_o) hi_q <= hi_q + 1'b1;
    end else if (done_o) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (armed_o) begin
      lo_q <= lo_q + 1'b1;
    end else begin
      hi_q <= '0;
    end
  end
endmodule

// File: rtl/swd_link.sv
module swd_link
  import swd_pkg::*;
#(
  parameter int LR_HIGH = 50,
  parameter int LR_LOW  = 2,
  parameter int DW      = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          swdio_i,
  output logic          swdio_o,
  output logic          swdio_oe_o,
  input  logic          fault_i,
  input  logic [DW-1:0] rdata_i,
  output logic          acc_stb_o,
  output logic          acc_ap_o,
  output logic          acc_wr_o,
  output logic [1:0]    acc_a_o,
  output logic [DW-1:0] wdata_o,
  output logic          wderr_o
);
  localparam int CW = $clog2(DW + 1);

  swd_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [6:0]    req_q;
  logic [DW-1:0] sh_q;
  logic          par_q, dout_q, oe_q, id_ok_q, seen_q;
  logic [2:0]    ack_q;
  logic          lr_armed, lr_done;

  swd_line_reset #(.LR_HIGH(LR_HIGH), .LR_LOW(LR_LOW)) u_lr (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(swdio_i),
    .armed_o(lr_armed), .done_o(lr_done)
  );

  // request bits, LSB = first after start
  logic [6:0] req_full;
  logic       frame_ok, is_idr, allow, faulty, rd_stb, wr_stb, wd_bad;
  assign req_full = {swdio_i, req_q[6:1]};
  assign frame_ok = !req_full[5] && req_full[6] && (req_full[4] == ^req_full[3:0]);
  assign is_idr   = !req_full[0] && req_full[1] && (req_full[3:2] == 2'd0);
  assign allow    = frame_ok && (id_ok_q || is_idr);
  assign faulty   = fault_i && (req_full[0] || (req_full[1] && req_full[3:2] == 2'd3));

  assign rd_stb = (state_q == ST_ACK) && (cnt_q == CW'(2)) && (ack_q == ACK_OK) && req_q[1];
  assign wd_bad = (^sh_q) != swdio_i;
  assign wr_stb = (state_q == ST_WDATA) && (cnt_q == CW'(DW)) && !wd_bad;

  assign acc_stb_o  = rd_stb || wr_stb;
  assign acc_wr_o   = wr_stb;
  assign acc_ap_o   = req_q[0];
  assign acc_a_o    = req_q[3:2];
  assign wdata_o    = sh_q;
  assign wderr_o    = (state_q == ST_WDATA) && (cnt_q == CW'(DW)) && wd_bad;
  assign swdio_o    = dout_q;
  assign swdio_oe_o = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RST;
      cnt_q   <= '0;
      req_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      dout_q  <= 1'b0;
      oe_q    <= 1'b0;
      ack_q   <= ACK_OK;
      id_ok_q <= 1'b0;
      seen_q  <= 1'b0;
    end else if (lr_done) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
      seen_q  <= 1'b1;
      id_ok_q <= 1'b0;
    end else if (lr_armed && state_q != ST_RST) begin
      state_q <= ST_RST;
      oe_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (swdio_i) begin
          state_q <= ST_REQ;
          cnt_q   <= '0;
        end
        ST_REQ: begin
          req_q <= req_full;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(6)) begin
            state_q <= allow ? ST_TRN1 : ST_IDLE;
            ack_q   <= faulty ? ACK_FAULT : ACK_OK;
          end
        end
        ST_TRN1: begin
          dout_q  <= ack_q[0];
          oe_q    <= 1'b1;
          cnt_q   <= '0;
          state_q <= ST_ACK;
        end
        ST_ACK: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(0)) dout_q <= ack_q[1];
          else if (cnt_q == CW'(1)) dout_q <= ack_q[2];
          else begin
            cnt_q <= '0;
            if (ack_q != ACK_OK) begin
              oe_q    <= 1'b0;
              state_q <= ST_IDLE;
            end else if (req_q[1]) begin
              sh_q    <= rdata_i;
              dout_q  <= rdata_i[0];
              par_q   <= ^rdata_i;
              state_q <= ST_RDATA;
              if (!req_q[0] && req_q[3:2] == 2'd0) id_ok_q <= 1'b1;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_TRN2;
            end
          end
        end
        ST_RDATA: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q < CW'(DW - 1)) begin
            dout_q <= sh_q[1];
            sh_q   <= sh_q >> 1;
          end else if (cnt_q == CW'(DW - 1)) begin
            dout_q <= par_q;
          end else begin
            oe_q    <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        ST_TRN2: begin
          cnt_q   <= '0;
          state_q <= ST_WDATA;
        end
        ST_WDATA: begin
          if (cnt_q < CW'(DW)) begin
            sh_q  <= {swdio_i, sh_q[DW-1:1]};
            cnt_q <= cnt_q + 1'b1;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  assert_undriven_before_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> !swdio_oe_o);
  assert_lockout_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TRN1) |-> (id_ok_q || (!req_q[0] && req_q[1] && req_q[3:2] == 2'd0)));
  assert_bad_frame_no_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REQ && cnt_q == CW'(6) && !frame_ok && !lr_armed && !lr_done)
      |=> (state_q == ST_IDLE && !swdio_oe_o));
  assert_oe_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swdio_oe_o |-> (state_q == ST_ACK || state_q == ST_RDATA));
endmodule

// File: rtl/swd_regs.sv
module swd_regs #(
  parameter logic [31:0] DP_ID = 32'h0BB1_1477,
  parameter logic [31:0] AP_ID = 32'h0477_0021,
  parameter int          DW    = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_stb_i,
  input  logic          acc_ap_i,
  input  logic          acc_wr_i,
  input  logic [1:0]    acc_a_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wderr_i,
  output logic [DW-1:0] rdata_o,
  output logic          fault_o,
  output logic          sys_req_o,
  output logic          dbg_req_o,
  output logic          ap_req_o,
  output logic          ap_wr_o,
  output logic [7:0]    ap_sel_o,
  output logic [7:0]    ap_addr_o,
  output logic [DW-1:0] ap_wdata_o,
  input  logic [DW-1:0] ap_rdata_i
);
  logic          sys_req_q, dbg_req_q, sys_ack_q, dbg_ack_q, werr_q;
  logic [7:0]    apsel_q;
  logic [3:0]    bank_q;
  logic [DW-1:0] rdbuf_q, scratch_q, ap_val, ctrl;
  logic [7:0]    addr;
  logic          int_ap;

  assign addr   = {bank_q, acc_a_i, 2'b00};
  assign int_ap = (apsel_q == 8'd0);
  assign ctrl   = {sys_ack_q, sys_req_q, dbg_ack_q, dbg_req_q, 20'd0, werr_q, 7'd0};

  always_comb begin
    if (!int_ap)               ap_val = ap_rdata_i;
    else if (addr == 8'hFC)    ap_val = AP_ID;
    else if (addr == 8'h00)    ap_val = scratch_q;
    else                       ap_val = '0;
  end

  always_comb begin
    if (acc_ap_i) rdata_o = rdbuf_q;  // posted: old result goes out
    else begin
      case (acc_a_i)
        2'd0:    rdata_o = DP_ID;
        2'd1:    rdata_o = ctrl;
        2'd2:    rdata_o = {apsel_q, 16'd0, bank_q, 4'd0};
        default: rdata_o = rdbuf_q;
      endcase
    end
  end

  assign fault_o    = werr_q;
  assign sys_req_o  = sys_req_q;
  assign dbg_req_o  = dbg_req_q;
  assign ap_req_o   = acc_stb_i && acc_ap_i && !int_ap;
  assign ap_wr_o    = acc_wr_i;
  assign ap_sel_o   = apsel_q;
  assign ap_addr_o  = addr;
  assign ap_wdata_o = wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sys_req_q <= 1'b0;
      dbg_req_q <= 1'b0;
      sys_ack_q <= 1'b0;
      dbg_ack_q <= 1'b0;
      werr_q    <= 1'b0;
      apsel_q   <= '0;
      bank_q    <= '0;
      rdbuf_q   <= '0;
      scratch_q <= '0;
    end else begin
      sys_ack_q <= sys_req_q;
      dbg_ack_q <= dbg_req_q;
      if (wderr_i) werr_q <= 1'b1;
      if (acc_stb_i) begin
        if (acc_ap_i) begin
          if (!acc_wr_i) rdbuf_q <= ap_val;
          else if (int_ap && addr == 8'h00) scratch_q <= wdata_i;
        end else if (acc_wr_i) begin
          case (acc_a_i)
            2'd0: if (wdata_i[3]) werr_q <= 1'b0;
            2'd1: begin
              sys_req_q <= wdata_i[30];
              dbg_req_q <= wdata_i[28];
            end
            2'd2: begin
              apsel_q <= wdata_i[31:24];
              bank_q  <= wdata_i[7:4];
            end
            default: ;
          endcase
        end
      end
    end
  end

  assert_ack_follows_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_ack_q) |-> $past(sys_req_q));
  assert_bad_wdata_no_update_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wderr_i |=> (werr_q && apsel_q == $past(apsel_q) && bank_q == $past(bank_q)));
  assert_fault_blocks_ap_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && acc_stb_i) |-> !acc_ap_i);
endmodule

// File: rtl/swd_target.sv
module swd_target #(
  parameter logic [31:0] DP_IDCODE = 32'h0BB1_1477,
  parameter logic [31:0] AP0_IDR   = 32'h0477_0021,
  parameter int          LR_HIGH   = 50,
  parameter int          LR_LOW    = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        swdio_i,
  output logic        swdio_o,
  output logic        swdio_oe_o,
  output logic        sys_pwrup_req_o,
  output logic        dbg_pwrup_req_o,
  output logic        ap_req_o,
  output logic        ap_wr_o,
  output logic [7:0]  ap_sel_o,
  output logic [7:0]  ap_addr_o,
  output logic [31:0] ap_wdata_o,
  input  logic [31:0] ap_rdata_i
);
  localparam int DW = 32;

  logic          acc_stb, acc_ap, acc_wr, wderr, fault;
  logic [1:0]    acc_a;
  logic [DW-1:0] wdata, rdata;

  swd_link #(.LR_HIGH(LR_HIGH), .LR_LOW(LR_LOW), .DW(DW)) u_link (
    .clk_i(clk_i), .rst_ni(rst_ni), .swdio_i(swdio_i),
    .swdio_o(swdio_o), .swdio_oe_o(swdio_oe_o),
    .fault_i(fault), .rdata_i(rdata),
    .acc_stb_o(acc_stb), .acc_ap_o(acc_ap), .acc_wr_o(acc_wr),
    .acc_a_o(acc_a), .wdata_o(wdata), .wderr_o(wderr)
  );

  swd_regs #(.DP_ID(DP_IDCODE), .AP_ID(AP0_IDR), .DW(DW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .acc_stb_i(acc_stb), .acc_ap_i(acc_ap), .acc_wr_i(acc_wr),
    .acc_a_i(acc_a), .wdata_i(wdata), .wderr_i(wderr),
    .rdata_o(rdata), .fault_o(fault),
    .sys_req_o(sys_pwrup_req_o), .dbg_req_o(dbg_pwrup_req_o),
    .ap_req_o(ap_req_o), .ap_wr_o(ap_wr_o), .ap_sel_o(ap_sel_o),
    .ap_addr_o(ap_addr_o), .ap_wdata_o(ap_wdata_o), .ap_rdata_i(ap_rdata_i)
  );
endmodule

// File: tb/swd_target_test.sv
module swd_target_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_bit = 1'b0;
  logic        swdio_o, swdio_oe, sys_req, dbg_req;
  logic        ap_req, ap_wr;
  logic [7:0]  ap_sel, ap_addr;
  logic [31:0] ap_wdata, ap_rdata;
  logic        wire_v;
  int          checks = 0, errors = 0;
  logic [7:0]  bw_sel, bw_addr;
  logic [31:0] bw_data;
  logic        bw_seen = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  assign wire_v   = swdio_oe ? swdio_o : host_bit;
  assign ap_rdata = {ap_sel, ap_addr, 16'hBEEF};

  swd_target uut (
    .clk_i(clk), .rst_ni(rst_n), .swdio_i(wire_v),
    .swdio_o(swdio_o), .swdio_oe_o(swdio_oe),
    .sys_pwrup_req_o(sys_req), .dbg_pwrup_req_o(dbg_req),
    .ap_req_o(ap_req), .ap_wr_o(ap_wr), .ap_sel_o(ap_sel),
    .ap_addr_o(ap_addr), .ap_wdata_o(ap_wdata), .ap_rdata_i(ap_rdata)
  );

  always @(posedge clk) if (ap_req && ap_wr) begin
    bw_sel <= ap_sel; bw_addr <= ap_addr; bw_data <= ap_wdata; bw_seen <= 1'b1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); host_bit = 1'b0; end
  endtask

  task automatic line_reset();
    for (int i = 0; i < 56; i++) begin @(negedge clk); host_bit = 1'b1; end
    idle(4);
  endtask

  // ack 3'b000 means no acknowledge seen
  task automatic xfer(input logic ap, input logic rnw, input logic [1:0] a,
                      input logic [31:0] wd, input logic bad_rp, input logic bad_stop,
                      input logic bad_wp, output logic [2:0] ack,
                      output logic [31:0] rd, output logic rp);
    logic [7:0] bits;
    logic       none;
    bits = {1'b1, bad_stop, (^{a[1], a[0], rnw, ap}) ^ bad_rp, a[1], a[0], rnw, ap, 1'b1};
    ack = 3'b000; rd = '0; rp = 1'b0; none = 1'b0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); host_bit = bits[i]; end
    @(negedge clk); host_bit = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (!swdio_oe) none = 1'b1;
      ack[i] = swdio_o;
    end
    if (none) ack = 3'b000;
    if (ack == 3'b001) begin
      if (rnw) begin
        for (int i = 0; i < 32; i++) begin @(negedge clk); rd[i] = swdio_o; end
        @(negedge clk); rp = swdio_o;
      end else begin
        @(negedge clk);
        for (int i = 0; i < 32; i++) begin @(negedge clk); host_bit = wd[i]; end
        @(negedge clk); host_bit = (^wd) ^ bad_wp;
      end
    end
    idle(3);
  endtask

  typedef struct packed {
    logic        ap;
    logic        rnw;
    logic [1:0]  a;
    logic [31:0] wd;
    logic [31:0] rd;
  } vec_t;

  // all expect OK; reads check data and parity
  localparam vec_t VECS [16] = '{
    '{1'b0, 1'b1, 2'd0, 32'h0,          32'h0BB1_1477},  // R2 idcode
    '{1'b0, 1'b0, 2'd1, 32'h5000_0000,  32'h0},          // R6 power-up
    '{1'b0, 1'b1, 2'd1, 32'h0,          32'hF000_0000},  // R6 acks
    '{1'b0, 1'b0, 2'd2, 32'h0000_00F0,  32'h0},          // R7 bank F
    '{1'b1, 1'b1, 2'd3, 32'h0,          32'h0},          // R8 stale
    '{1'b0, 1'b1, 2'd3, 32'h0,          32'h0477_0021},  // R9 via buffer
    '{1'b0, 1'b0, 2'd2, 32'h0,          32'h0},
    '{1'b1, 1'b0, 2'd0, 32'hA5A5_0F0F,  32'h0},          // R9 scratch
    '{1'b1, 1'b1, 2'd0, 32'h0,          32'h0477_0021},
    '{1'b1, 1'b1, 2'd0, 32'h0,          32'hA5A5_0F0F},
    '{1'b0, 1'b1, 2'd3, 32'h0,          32'hA5A5_0F0F},
    '{1'b0, 1'b0, 2'd2, 32'h0200_0010,  32'h0},          // R10 port 2 bank 1
    '{1'b1, 1'b0, 2'd1, 32'h1234_5678,  32'h0},
    '{1'b1, 1'b1, 2'd2, 32'h0,          32'hA5A5_0F0F},
    '{1'b0, 1'b1, 2'd3, 32'h0,          32'h0218_BEEF},
    '{1'b0, 1'b1, 2'd2, 32'h0,          32'h0200_0010}   // R7 readback
  };

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0]  ack;
    logic [31:0] rd;
    logic        rp;
    idle(3);
    chk("reset oe", {31'd0, swdio_oe}, 32'd0);
    chk("reset pwrup R6", {30'd0, sys_req, dbg_req}, 32'd0);
    rst_n = 1'b1;
    idle(3);

    // R1: no answer before the first line reset
    xfer(1'b0, 1'b1, 2'd0, 0, 1'b0, 1'b0, 1'b0, ack, rd, rp);
    chk("R1 no ack before line reset", {29'd0, ack}, 32'd0);

    line_reset();
    // R2: lockout until identification read
    xfer(1'b0, 1'b1, 2'd1, 0, 1'b0, 1'b0, 1'b0, ack, rd, rp);
    chk("R2 lockout before idcode", {29'd0, ack}, 32'd0);

    for (int i = 0; i < 16; i++) begin
      xfer(VECS[i].ap, VECS[i].rnw, VECS[i].a, VECS[i].wd, 1'b0, 1'b0, 1'b0, ack, rd, rp);
      chk($sformatf("R4 vec%0d ack", i), {29'd0, ack}, 32'd1);
      if (VECS[i].rnw) begin
        chk($sformatf("R8 vec%0d data", i), rd, VECS[i].rd);
        chk($sformatf("R5 vec%0d parity", i), {31'd0, rp}, {31'd0, ^rd});
      end
    end
    chk("R6 pwrup outputs", {30'd0, sys_req, dbg_req}, 32'd3);
    chk("R10 bus write", {bw_sel, bw_addr, 15'd0, bw_seen}, {8'd2, 8'h14, 16'd1});
    chk("R10 bus wdata", bw_data, 32'h1234_5678);

    // R3: framing errors
    xfer(1'b0, 1'b1, 2'd0, 0, 1'b1, 1'b0, 1'b0, ack, rd, rp);
    chk("R3 bad request parity", {29'd0, ack}, 32'd0);
    xfer(1'b0, 1'b1, 2'd0, 0, 1'b0, 1'b1, 1'b0, ack, rd, rp);
    chk("R3 bad stop bit", {29'd0, ack}, 32'd0);

    // R11: corrupted write data
    xfer(1'b0, 1'b0, 2'd2, 32'h0F00_0000, 1'b0, 1'b0, 1'b1, ack, rd, rp);
    chk("R11 bad wdata ack", {29'd0, ack}, 32'd1);
    xfer(1'b0, 1'b1, 2'd2, 0, 1'b0, 1'b0, 1'b0, ack, rd, rp);
    chk("R11 select unchanged", rd, 32'h0200_0010);
    xfer(1'b0, 1'b1, 2'd1, 0, 1'b0, 1'b0, 1'b0, ack, rd, rp);
    chk("R11 sticky set", rd, 32'hF000_0080);

    // R12: fault while sticky
    xfer(1'b1, 1'b1, 2'd0, 0, 1'b0, 1'b0, 1'b0, ack, rd, rp);
    chk("R12 ap read fault", {29'd0, ack}, 32'd4);
    xfer(1'b0, 1'b1, 2'd3, 0, 1'b0, 1'b0, 1'b0, ack, rd, rp);
    chk("R12 rdbuff fault", {29'd0, ack}, 32'd4);
    xfer(1'b0, 1'b0, 2'd0, 32'h8, 1'b0, 1'b0, 1'b0, ack, rd, rp);
    chk("R12 clear ack", {29'd0, ack}, 32'd1);
    xfer(1'b0, 1'b1, 2'd1, 0, 1'b0, 1'b0, 1'b0, ack, rd, rp);
    chk("R12 sticky cleared", rd, 32'hF000_0000);
    xfer(1'b0, 1'b1, 2'd3, 0, 1'b0, 1'b0, 1'b0, ack, rd, rp);
    chk("R12 rdbuff after clear", rd, 32'h0218_BEEF);

    // R1/R2: a new line reset re-arms the lockout
    line_reset();
    xfer(1'b0, 1'b1, 2'd1, 0, 1'b0, 1'b0, 1'b0, ack, rd, rp);
    chk("R2 lockout after new reset", {29'd0, ack}, 32'd0);
    xfer(1'b0, 1'b1, 2'd0, 0, 1'b0, 1'b0, 1'b0, ack, rd, rp);
    chk("R2 idcode after new reset", rd, 32'h0BB1_1477);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule